// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides which of five interrupt sources an 8-bit CPU core services next. The sources are a non-maskable trap input, an edge-triggered restart input (level 7.5), two level-triggered restart inputs (levels 6.5 and 5.5), and a general request whose vector is supplied by an external device during an acknowledge cycle. The block holds the three restart masks, the global interrupt enable, the latch that remembers an edge on the 7.5 input, and the qualifier that makes the trap input both edge- and level-sensitive.

The core talks to it with single-cycle pulses. A sample strobe, issued one clock before an instruction ends (or while the core is halted or holding), freezes the current winner into a grant register. Enable, disable, set-mask and read-mask commands carry the accumulator byte. An acknowledge pulse tells the block that the granted interrupt is now being serviced. The grant gives the winning source, its restart address and a flag that says an external acknowledge cycle must fetch the instruction. The read-mask command returns a status byte that also carries the serial input pin. The set-mask command can drive the serial output pin.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When several eligible requests are present at a sample strobe, the grant goes to the highest-ranked one; the ranking from the top is trap, 7.5, 6.5, 5.5, general request.
- R2: The grant reports the source on `req_src_o` as 1 for trap, 2 for 7.5, 3 for 6.5, 4 for 5.5, 5 for the general request and 0 for none. `vector_o` is 0x24 for trap, 0x3C for 7.5, 0x34 for 6.5, 0x2C for 5.5, and 0x00 for the general request or for none. `inta_o` is 1 only when the general request is granted.
- R3: The grant outputs change only in the cycle after a sample strobe or after an acknowledge. A request that comes and goes between strobes is never granted. A strobe that finds no eligible request drives `req_valid_o` to 0 and the source and vector to 0.
- R4: A rising edge on the 7.5 input sets a pending latch, even while 7.5 is masked. The latch clears when 7.5 is acknowledged, when a set-mask command has bit 4 set, or on reset. An input that is already high when reset ends does not count as an edge.
- R5: The trap input is granted regardless of the masks and the interrupt enable. It needs a rising edge and must still be high at the strobe. Once it has been acknowledged, it is not granted again until the pin has gone low and then high.
- R6: An acknowledge while `req_valid_o` is 1 clears the grant and clears the interrupt enable. An acknowledge while `req_valid_o` is 0 has no effect.
- R7: An enable command sets the interrupt enable and a disable command clears it. The restart inputs and the general request are eligible only while the enable is set.
- R8: Acknowledging a trap saves the enable value held before the acknowledge. The first read-mask command after that reports the saved value in bit 3, and later read-mask commands report the current enable.
- R9: Reset clears the grant, the interrupt enable, the 7.5 latch, the serial output and the read-mask byte, and sets all three masks.
- R10: In a set-mask command, bit 3 enables loading the masks from bit 2 (7.5), bit 1 (6.5) and bit 0 (5.5); with bit 3 at 0 the masks keep their values. Bit 6 enables loading `sod_o` from bit 7; with bit 6 at 0, `sod_o` keeps its value.
- R11: A read-mask command loads `rim_data_o` in the next cycle with the masks in bits 2..0 (7.5, 6.5, 5.5 from bit 2 down), the enable in bit 3, the pending state in bits 6..4 (the 7.5 latch, then the 6.5 and 5.5 pins from bit 6 down), and `sid_i` in bit 7.
- R12: A masked restart source is never granted; at the same strobe, the highest unmasked eligible source wins instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_i | input | 1 | Non-maskable trap request pin |
| r75_i | input | 1 | Edge-triggered restart request, level 7.5 |
| r65_i | input | 1 | Level restart request, level 6.5 |
| r55_i | input | 1 | Level restart request, level 5.5 |
| intr_i | input | 1 | General request that needs an external acknowledge cycle |
| sid_i | input | 1 | Serial input data bit |
| sample_i | input | 1 | Sample strobe from the core |
| ei_i | input | 1 | Enable-interrupts command pulse |
| di_i | input | 1 | Disable-interrupts command pulse |
| sim_i | input | 1 | Set-mask command pulse |
| rim_i | input | 1 | Read-mask command pulse |
| acc_i | input | 8 | Accumulator byte for the set-mask command |
| ack_i | input | 1 | Service acknowledge from the core |
| req_valid_o | output | 1 | A granted interrupt is waiting |
| req_src_o | output | 3 | Granted source code |
| vector_o | output | 8 | Restart address of the granted source |
| inta_o | output | 1 | Grant needs an external acknowledge cycle |
| rim_data_o | output | 8 | Status byte from the last read-mask command |
| sod_o | output | 1 | Serial output data bit |

## Verification
The hardest situation to reach is the saved-enable report after a trap. It needs a trap that is qualified by a rising edge, granted while the enable is set, then acknowledged, and then two read-mask commands in a row that must disagree in bit 3. The stimulus first shows that a trap pin left high is not granted again, then lowers and raises the pin with the enable set, and reads the status twice. A similar path proves that a masked 7.5 edge is held as pending: the status byte shows the latch set while a lower-ranked unmasked source takes the grant, and a clear through set-mask bit 4 then shows it gone.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W = 8;
    localparam int VEC_W  = 8;
    localparam int NSRC   = 5;
    localparam int NEDGE  = 2;
    localparam int SRC_W  = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_INTR = 3'd5
    } irq_src_e;

    localparam logic [VEC_W-1:0] VEC_TRAP = 8'h24;
    localparam logic [VEC_W-1:0] VEC_R75  = 8'h3C;
    localparam logic [VEC_W-1:0] VEC_R65  = 8'h34;
    localparam logic [VEC_W-1:0] VEC_R55  = 8'h2C;

    // set-mask command byte fields
    localparam int SM_MASK_LO = 0;
    localparam int SM_LOAD    = 3;
    localparam int SM_CLR75   = 4;
    localparam int SM_SODEN   = 6;
    localparam int SM_SODVAL  = 7;

    // read-mask status byte fields
    localparam int RS_IE   = 3;
    localparam int RS_PEND = 4;
    localparam int RS_SID  = 7;

    // edge cell indices
    localparam int EDGE_TRAP = 0;
    localparam int EDGE_R75  = 1;

    typedef struct packed {
        logic              valid;
        irq_src_e          src;
        logic [VEC_W-1:0]  vec;
        logic              inta;
    } irq_grant_t;

    function automatic logic [VEC_W-1:0] vec_of(input irq_src_e s);
        logic [VEC_W-1:0] v;
        case (s)
            SRC_TRAP: v = VEC_TRAP;
            SRC_R75:  v = VEC_R75;
            SRC_R65:  v = VEC_R65;
            SRC_R55:  v = VEC_R55;
            default:  v = '0;
        endcase
        return v;
    endfunction

    function automatic irq_src_e src_of_rank(input int rank);
        return irq_src_e'(SRC_W'(rank + 1));
    endfunction

endpackage

// File: rtl/irq_edge_cell.sv
module irq_edge_cell (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    // history follows the pin even in reset, so a pin high out of reset is no edge
    always_ff @(posedge clk) prev_q <= pin_i;

    assign rise = pin_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (rise)
            pend_q <= 1'b1;
        else if (clr_i)
            pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    a_r4_edge_sets: assert property (@(posedge clk) disable iff (rst)
        $rose(pin_i) |=> pend_o);

    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !$rose(pin_i)) |=> !pend_o);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic             ack_i,
    input  logic [N-1:0]     elig_i,
    output irq_grant_t       grant_o,
    output logic             ack_fire_o,
    output irq_src_e         ack_src_o
);
    irq_grant_t pick;
    irq_grant_t grant_q;
    logic       found;

    // rank 0 is the highest priority
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && elig_i[i]) begin
                found    = 1'b1;
                pick.src = src_of_rank(i);
            end
        end
        pick.valid = found;
        pick.vec   = vec_of(pick.src);
        pick.inta  = (pick.src == SRC_INTR);
    end

    assign ack_fire_o = ack_i & grant_q.valid;
    assign ack_src_o  = grant_q.src;

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= '0;
        else if (ack_fire_o)
            grant_q <= '0;
        else if (sample_i)
            grant_q <= pick;
    end

    assign grant_o = grant_q;

    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!sample_i && !ack_i) |=> $stable(grant_o));

    a_r6_ack_drops: assert property (@(posedge clk) disable iff (rst)
        ack_fire_o |=> !grant_o.valid);

    a_r2_inta_only_general: assert property (@(posedge clk) disable iff (rst)
        grant_o.inta |-> (grant_o.valid && grant_o.src == SRC_INTR));

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              sim_i,
    input  logic              rim_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              sid_i,
    input  logic              ack_fire_i,
    input  irq_src_e          ack_src_i,
    input  logic              pend75_i,
    input  logic              pin65_i,
    input  logic              pin55_i,
    output logic              ie_o,
    output logic [2:0]        mask_o,
    output logic              clr75_o,
    output logic              sod_o,
    output logic [DATA_W-1:0] rim_o
);
    logic              ie_q;
    logic              saved_ie_q;
    logic              after_trap_q;
    logic [2:0]        mask_q;
    logic              sod_q;
    logic [DATA_W-1:0] rim_q;
    logic [DATA_W-1:0] status;
    logic              mask_load;
    logic              trap_ack;
    logic              unused_acc_b5;

    assign unused_acc_b5 = acc_i[5];
    assign mask_load     = sim_i & acc_i[SM_LOAD];
    assign trap_ack      = ack_fire_i & (ack_src_i == SRC_TRAP);
    assign clr75_o       = sim_i & acc_i[SM_CLR75];

    always_ff @(posedge clk) begin
        if (rst)
            ie_q <= 1'b0;
        else if (ack_fire_i)
            ie_q <= 1'b0;
        else if (ei_i)
            ie_q <= 1'b1;
        else if (di_i)
            ie_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_ie_q   <= 1'b0;
            after_trap_q <= 1'b0;
        end else if (trap_ack) begin
            saved_ie_q   <= ie_q;
            after_trap_q <= 1'b1;
        end else if (rim_i) begin
            after_trap_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (mask_load)
            mask_q <= acc_i[SM_MASK_LO +: 3];
    end

    always_ff @(posedge clk) begin
        if (rst)
            sod_q <= 1'b0;
        else if (sim_i && acc_i[SM_SODEN])
            sod_q <= acc_i[SM_SODVAL];
    end

    always_comb begin
        status                  = '0;
        status[SM_MASK_LO +: 3] = mask_q;
        status[RS_IE]           = after_trap_q ? saved_ie_q : ie_q;
        status[RS_PEND +: 3]    = {pend75_i, pin65_i, pin55_i};
        status[RS_SID]          = sid_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rim_q <= '0;
        else if (rim_i)
            rim_q <= status;
    end

    assign ie_o   = ie_q;
    assign mask_o = mask_q;
    assign sod_o  = sod_q;
    assign rim_o  = rim_q;

    a_r6_ack_clears_ie: assert property (@(posedge clk) disable iff (rst)
        ack_fire_i |=> !ie_o);

    a_r7_ei_sets: assert property (@(posedge clk) disable iff (rst)
        (ei_i && !ack_fire_i) |=> ie_o);

    a_r10_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !(sim_i && acc_i[SM_LOAD]) |=> $stable(mask_o));

    a_r10_sod_hold: assert property (@(posedge clk) disable iff (rst)
        !(sim_i && acc_i[SM_SODEN]) |=> $stable(sod_o));

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_i,
    input  logic              r75_i,
    input  logic              r65_i,
    input  logic              r55_i,
    input  logic              intr_i,
    input  logic              sid_i,
    input  logic              sample_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              sim_i,
    input  logic              rim_i,
    input  logic [7:0]        acc_i,
    input  logic              ack_i,
    output logic              req_valid_o,
    output logic [2:0]        req_src_o,
    output logic [7:0]        vector_o,
    output logic              inta_o,
    output logic [7:0]        rim_data_o,
    output logic              sod_o
);
    logic [NEDGE-1:0] edge_pin;
    logic [NEDGE-1:0] edge_clr;
    logic [NEDGE-1:0] edge_pend;
    logic [NSRC-1:0]  elig;
    logic             ie;
    logic [2:0]       mask;
    logic             clr75_sim;
    logic             ack_fire;
    irq_src_e         ack_src;
    irq_grant_t       grant;

    assign edge_pin[EDGE_TRAP] = trap_i;
    assign edge_pin[EDGE_R75]  = r75_i;
    assign edge_clr[EDGE_TRAP] = ack_fire & (ack_src == SRC_TRAP);
    assign edge_clr[EDGE_R75]  = (ack_fire & (ack_src == SRC_R75)) | clr75_sim;

    for (genvar g = 0; g < NEDGE; g++) begin : g_edge
        irq_edge_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (edge_pin[g]),
            .clr_i  (edge_clr[g]),
            .pend_o (edge_pend[g])
        );
    end

    // eligibility by rank: trap, 7.5, 6.5, 5.5, general
    assign elig[0] = edge_pend[EDGE_TRAP] & trap_i;
    assign elig[1] = edge_pend[EDGE_R75] & ~mask[2] & ie;
    assign elig[2] = r65_i & ~mask[1] & ie;
    assign elig[3] = r55_i & ~mask[0] & ie;
    assign elig[4] = intr_i & ie;

    irq_arbiter #(.N(NSRC)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .sample_i   (sample_i),
        .ack_i      (ack_i),
        .elig_i     (elig),
        .grant_o    (grant),
        .ack_fire_o (ack_fire),
        .ack_src_o  (ack_src)
    );

    irq_ctl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .sim_i      (sim_i),
        .rim_i      (rim_i),
        .acc_i      (acc_i),
        .sid_i      (sid_i),
        .ack_fire_i (ack_fire),
        .ack_src_i  (ack_src),
        .pend75_i   (edge_pend[EDGE_R75]),
        .pin65_i    (r65_i),
        .pin55_i    (r55_i),
        .ie_o       (ie),
        .mask_o     (mask),
        .clr75_o    (clr75_sim),
        .sod_o      (sod_o),
        .rim_o      (rim_data_o)
    );

    assign req_valid_o = grant.valid;
    assign req_src_o   = grant.src;
    assign vector_o    = grant.vec;
    assign inta_o      = grant.inta;

    a_r5_trap_first: assert property (@(posedge clk) disable iff (rst)
        (sample_i && !ack_i && trap_i && edge_pend[EDGE_TRAP]) |=> (req_src_o == 3'(SRC_TRAP)));

    a_r7_disabled_only_trap: assert property (@(posedge clk) disable iff (rst)
        (sample_i && !ack_i && !ie) |=> (!req_valid_o || req_src_o == 3'(SRC_TRAP)));

endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;

    localparam int K_REQ = 0;
    localparam int K_RIM = 1;
    localparam int K_SOD = 2;

    typedef struct {
        int          due;
        int          kind;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trap_i = 0, r75_i = 0, r65_i = 0, r55_i = 0, intr_i = 0, sid_i = 0;
    logic sample_i = 0, ei_i = 0, di_i = 0, sim_i = 0, rim_i = 0, ack_i = 0;
    logic [7:0] acc_i = '0;
    logic       req_valid_o, inta_o, sod_o;
    logic [2:0] req_src_o;
    logic [7:0] vector_o, rim_data_o;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst(rst), .trap_i(trap_i), .r75_i(r75_i), .r65_i(r65_i),
        .r55_i(r55_i), .intr_i(intr_i), .sid_i(sid_i), .sample_i(sample_i),
        .ei_i(ei_i), .di_i(di_i), .sim_i(sim_i), .rim_i(rim_i), .acc_i(acc_i),
        .ack_i(ack_i), .req_valid_o(req_valid_o), .req_src_o(req_src_o),
        .vector_o(vector_o), .inta_o(inta_o), .rim_data_o(rim_data_o), .sod_o(sod_o)
    );

    function automatic logic [15:0] pk(input logic v, input logic [2:0] s,
                                       input logic a, input logic [7:0] vec);
        return {3'b000, v, s, a, vec};
    endfunction

    // monitor: pops expected items as they fall due and compares
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                logic [15:0] act;
                e = sb.pop_front();
                case (e.kind)
                    K_REQ:   act = pk(req_valid_o, req_src_o, inta_o, vector_o);
                    K_RIM:   act = {8'h00, rim_data_o};
                    default: act = {15'b0, sod_o};
                endcase
                checks++;
                if (act !== e.exp) begin
                    failures++;
                    $display("FAIL %s act=%h exp=%h", e.tag, act, e.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [15:0] exp, input string tag);
        exp_t e;
        e.due = cyc + 1; e.kind = kind; e.exp = exp; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic pulse(input logic s, input logic a, input logic e, input logic d,
                         input logic si, input logic ri, input logic [7:0] acc);
        sample_i = s; ack_i = a; ei_i = e; di_i = d; sim_i = si; rim_i = ri; acc_i = acc;
        @(negedge clk);
        sample_i = 0; ack_i = 0; ei_i = 0; di_i = 0; sim_i = 0; rim_i = 0; acc_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic smp(input string tag, input logic v, input logic [2:0] s,
                       input logic a, input logic [7:0] vec);
        push(K_REQ, pk(v, s, a, vec), tag);
        pulse(1, 0, 0, 0, 0, 0, 8'h00);
    endtask

    task automatic chk_req(input string tag, input logic v, input logic [2:0] s,
                           input logic a, input logic [7:0] vec);
        push(K_REQ, pk(v, s, a, vec), tag);
        @(negedge clk);
    endtask

    task automatic rim(input string tag, input logic [7:0] b);
        push(K_RIM, {8'h00, b}, tag);
        pulse(0, 0, 0, 0, 0, 1, 8'h00);
    endtask

    task automatic chk_sod(input string tag, input logic v);
        push(K_SOD, {15'b0, v}, tag);
        @(negedge clk);
    endtask

    task automatic sim(input logic [7:0] acc); pulse(0, 0, 0, 0, 1, 0, acc); endtask
    task automatic ei();  pulse(0, 0, 1, 0, 0, 0, 8'h00); endtask
    task automatic ack(); pulse(0, 1, 0, 0, 0, 0, 8'h00); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        // R9 reset state
        chk_req("R9 reset grant", 0, 0, 0, 8'h00);
        chk_sod("R9 reset sod", 0);
        rim("R9 R11 reset status", 8'h07);

        // R5 trap ignores enable and masks
        trap_i = 1; idle(1);
        smp("R5 trap while disabled", 1, 1, 0, 8'h24);
        push(K_REQ, pk(0, 0, 0, 8'h00), "R6 ack clears grant");
        ack();
        smp("R5 trap held high not regranted", 0, 0, 0, 8'h00);

        // R8 first status after trap reports saved enable
        trap_i = 0; ei(); sim(8'h08);
        rim("R8 first read after trap saved", 8'h00);
        rim("R8 second read current", 8'h08);

        // R1 priority with 7.5 edge, 6.5, 5.5, general all present
        r75_i = 1; r65_i = 1; r55_i = 1; intr_i = 1; sid_i = 1; idle(1);
        rim("R11 status layout with sid", 8'hF8);
        smp("R1 7.5 outranks lower", 1, 2, 0, 8'h3C);
        ack();
        smp("R6 ack disabled further grants", 0, 0, 0, 8'h00);
        rim("R4 ack cleared 7.5 latch", 8'hB0);

        ei();
        smp("R1 6.5 outranks 5.5", 1, 3, 0, 8'h34);
        ack();

        // R12 masked source skipped, R10 mask load gating
        ei(); sim(8'h0A); sim(8'h07);
        rim("R10 masks kept without load bit", 8'hBA);
        smp("R12 masked 6.5 skipped for 5.5", 1, 4, 0, 8'h2C);
        ack();

        r55_i = 0; ei();
        smp("R2 general request needs acknowledge", 1, 5, 1, 8'h00);
        ack();

        // R3 request between strobes is not granted
        intr_i = 0; ei();
        intr_i = 1; idle(2);
        chk_req("R3 no grant without strobe", 0, 0, 0, 8'h00);
        intr_i = 0;
        smp("R3 pulse gone before strobe", 0, 0, 0, 8'h00);

        // R4 masked 7.5 edge still latched, SIM bit 4 clears it
        sim(8'h0C);
        r75_i = 0; idle(1); r75_i = 1; idle(1);
        rim("R4 masked edge pending", 8'hEC);
        smp("R12 masked 7.5 skipped for 6.5", 1, 3, 0, 8'h34);
        sim(8'h10);
        rim("R4 set-mask clears 7.5 latch", 8'hAC);
        ack();
        r65_i = 0;

        // R10 serial output
        sim(8'hC0); chk_sod("R10 sod set", 1);
        sim(8'h80); chk_sod("R10 sod kept without enable", 1);
        sim(8'h40); chk_sod("R10 sod cleared", 0);

        // R8 trap taken while enabled
        ei(); trap_i = 1; intr_i = 1; idle(1);
        smp("R1 trap outranks general", 1, 1, 0, 8'h24);
        ack();
        trap_i = 0; intr_i = 0;
        rim("R8 saved enable after trap", 8'h8C);
        rim("R8 current enable later", 8'h84);

        // R4 R9 reset clears latch, pin high out of reset is no edge
        r75_i = 0; idle(1); r75_i = 1; idle(1);
        rst = 1; idle(2); rst = 0;
        rim("R4 reset cleared 7.5 latch", 8'h87);
        chk_req("R9 grant cleared by reset", 0, 0, 0, 8'h00);
        chk_sod("R9 sod cleared by reset", 0);
        idle(2);
        rim("R4 high pin after reset no edge", 8'h87);

        // R6 R7 ack with no grant is ignored
        ei(); ack();
        rim("R6 ack without grant ignored", 8'h8F);
        pulse(0, 0, 0, 1, 0, 0, 8'h00);
        rim("R7 disable clears enable", 8'h87);

        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule